// File: doc/BRIEF.md
# Shared-Counter Match Channel Array

This block holds eight timer channels, numbered 4 to 11 and indexed 0 to 7 inside the block. Each channel has a 32-bit counter, a 32-bit match register and a control register. A channel either advances its own counter from one of five tick-enable strobes, or follows the counter of its group leader and only compares. Channels 4, 8 and 10 are the group leaders. Channels 4 to 7 share counter 4, channels 8 and 9 share counter 8, and channels 10 and 11 share counter 10.

When the channel's source counter steps onto the value in the match register, the channel records a match. If the channel's enable input is high, the match sets the channel's status bit. The single interrupt output is high while any status bit is set. A channel can clear its counter on a match, and it can match repeatedly or only once. Reading counter 9 or counter 11 can copy the leader's count into a snapshot register. Software reaches all state through a word-aligned register port. The port has a combinational read path and a single-cycle write.

Top module: `match_chan_array`

## Requirements
- R1: After reset, all counters, match registers, control registers, status bits and the snapshot read 0, and `irqOut` is low.
- R2: A counter that runs its own clock advances by 1 on each clock cycle in which its selected strobe is high. Control bits [2:0] choose the strobe: 1 selects `tickStrobe[0]`, 2 selects bit 1, 3 selects bit 2, 4 selects bit 3 and 5 selects bit 4. Codes 0, 6 and 7 stop the counter, which then holds its value.
- R3: A write to a counter address (0x40 + 4·index) loads the written value. The load wins over any increment or clear in the same cycle.
- R4: Channels 5, 6, 7, 9 and 11 with control bit 7 clear do not advance their own counter. They compare against their leader's counter instead: index 0 for indices 1–3, index 4 for index 5, and index 6 for index 7. Channels 4, 8 and 10 always count from their own clock selection.
- R5: A match occurs in the cycle where the source counter advances and its incremented value equals the channel's match register, provided the channel is armed. A match sets `chanStatus[index]` (register 0x14, bit 4 + index) only when `chanIrqEn[index]` is high.
- R6: When control bit 3 is set on a channel that counts its own counter, a match loads that counter with 0 instead of the matched value.
- R7: When control bit 6 is set, the channel matches every time. When bit 6 is clear, the channel disarms after one match and re-arms on a write to its match or control register. All channels are armed after reset.
- R8: Control registers for indices 0–3 keep bits [7:0]. Those for indices 4–7 keep bits [9:0]. Higher written bits read back as 0.
- R9: On indices 4–7, control bit 8 stops the channel's clock, whatever bits [2:0] hold.
- R10: A read of address 0x54 while index 5 has control bit 9 set copies counter index 4 into the snapshot register (0x20). A read of 0x5C while index 7 has control bit 9 set copies counter index 6. Otherwise the snapshot keeps its value.
- R11: Writing 1 to bit 4 + index of address 0x14 clears that status bit. A match setting the same bit in the same cycle wins over the clear.
- R12: `irqOut` is high exactly while at least one status bit is set.
- R13: Reads return the match registers at 0x80 + 4·index and the control registers at 0xC0 + 4·index. Any other address, and any address with bits [1:0] nonzero, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickStrobe | input | 5 | Tick enables: 32.768 kHz, 1 kHz, 1 Hz, 1 MHz, external |
| chanIrqEn | input | 8 | Per-channel enable for status setting |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (drives the snapshot capture) |
| regAddr | input | 8 | Byte address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data |
| chanStatus | output | 8 | Status bits for channels 4–11 |
| irqOut | output | 1 | Combined interrupt |

## Verification
Suppose an armed flag is stuck wrong. A single-shot channel then either fires a second time or never fires after a re-arm, and `chanStatus` shows this on the cycle of the next qualifying step. Suppose a wrong strobe mapping or a wrong leader choice. The counter value read through the port then drifts from the expected count on the first tick, or the wrong status bit rises at the match. A bench model tracks every counter, flag and status bit cycle by cycle. It compares `chanStatus`, `irqOut` and the read data on every clock, so a divergence is reported in the cycle it first becomes visible.

// File: rtl/mca_pkg.sv
package mca_pkg;
  localparam int NUM_CH   = 8;
  localparam int IDX_W    = $clog2(NUM_CH);
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8;
  localparam int TICK_W   = 5;
  localparam int CTRL_W   = 10;
  localparam int STAT_LO  = 4;

  localparam logic [2:0] RG_CNT = 3'b010;
  localparam logic [2:0] RG_MAT = 3'b100;
  localparam logic [2:0] RG_CTL = 3'b110;
  localparam logic [ADDR_W-1:0] SNAP_ADDR = 8'h20;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 8'h14;
  localparam logic [ADDR_W-1:0] SNAP_LO_RD = 8'h54;
  localparam logic [ADDR_W-1:0] SNAP_HI_RD = 8'h5C;

  typedef struct packed {
    logic [NUM_CH-1:0] cntWr;
    logic [NUM_CH-1:0] matchWr;
    logic [NUM_CH-1:0] advance;
    logic [NUM_CH-1:0] clearCnt;
    logic [NUM_CH-1:0] slaveMode;
    logic              snapLo;
    logic              snapHi;
    logic [DATA_W-1:0] wrData;
  } strobe_t;

  function automatic int leaderOf(input int idx);
    if (idx < 4) return 0;
    else if (idx < 6) return 4;
    else return 6;
  endfunction
endpackage

// File: rtl/mca_ctrl.sv
module mca_ctrl
  import mca_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [TICK_W-1:0]             tickStrobe,
  input  logic [NUM_CH-1:0]             chanIrqEn,
  input  logic                          regWrEn,
  input  logic                          regRdEn,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [DATA_W-1:0]             regWrData,
  input  logic [NUM_CH-1:0]             hit,
  output strobe_t                       strb,
  output logic [NUM_CH-1:0][CTRL_W-1:0] ctrlOut,
  output logic [NUM_CH-1:0]             chanStatus
);
  logic [NUM_CH-1:0][CTRL_W-1:0] ctrlReg;
  logic [NUM_CH-1:0] ctrlWr, ownMode, tickSel, matchEvt, armed, periodicOn, rearm;
  logic [NUM_CH-1:0] statSet, statClr;
  logic              aligned, statWr;
  logic [2:0]        region;
  logic [IDX_W-1:0]  idx;

  assign aligned = (regAddr[1:0] == 2'b00);
  assign region  = regAddr[7:5];
  assign idx     = regAddr[2 +: IDX_W];
  assign statWr  = regWrEn && (regAddr == STAT_ADDR);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    localparam bit IS_LEADER = (i == 0) || (i == 4) || (i == 6);
    localparam logic [CTRL_W-1:0] WMASK = (i < 4) ? CTRL_W'(8'hFF) : {CTRL_W{1'b1}};
    logic [2:0] srcCode;

    assign ctrlWr[i]        = regWrEn && aligned && region == RG_CTL && idx == IDX_W'(i);
    assign strb.cntWr[i]    = regWrEn && aligned && region == RG_CNT && idx == IDX_W'(i);
    assign strb.matchWr[i]  = regWrEn && aligned && region == RG_MAT && idx == IDX_W'(i);
    assign ownMode[i]       = IS_LEADER || ctrlReg[i][7];
    assign strb.slaveMode[i] = !ownMode[i];
    assign periodicOn[i]    = ctrlReg[i][6];
    assign srcCode          = ctrlReg[i][8] ? 3'd0 : ctrlReg[i][2:0];

    always_comb begin
      case (srcCode)
        3'd1:    tickSel[i] = tickStrobe[0];
        3'd2:    tickSel[i] = tickStrobe[1];
        3'd3:    tickSel[i] = tickStrobe[2];
        3'd4:    tickSel[i] = tickStrobe[3];
        3'd5:    tickSel[i] = tickStrobe[4];
        default: tickSel[i] = 1'b0;
      endcase
    end

    assign strb.advance[i]  = ownMode[i] && tickSel[i] && !strb.cntWr[i];
    assign matchEvt[i]      = hit[i] && armed[i];
    assign strb.clearCnt[i] = matchEvt[i] && ownMode[i] && ctrlReg[i][3];
    assign rearm[i]         = strb.matchWr[i] || ctrlWr[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctrlReg[i] <= '0;
        armed[i]   <= 1'b1;
      end else begin
        if (ctrlWr[i]) ctrlReg[i] <= regWrData[CTRL_W-1:0] & WMASK;
        if (rearm[i]) armed[i] <= 1'b1;
        else if (matchEvt[i] && !periodicOn[i]) armed[i] <= 1'b0;
      end
    end
  end

  assign strb.wrData = regWrData;
  assign strb.snapLo = regRdEn && (regAddr == SNAP_LO_RD) && ctrlReg[5][9];
  assign strb.snapHi = regRdEn && (regAddr == SNAP_HI_RD) && ctrlReg[7][9];
  assign ctrlOut     = ctrlReg;

  assign statSet = matchEvt & chanIrqEn;
  assign statClr = statWr ? regWrData[STAT_LO +: NUM_CH] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chanStatus <= '0;
    else       chanStatus <= statSet | (chanStatus & ~statClr);
  end

  // R11: a cleared bit with no coincident set reads 0 in the next cycle
  assert_w1c_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
    (|(statClr & ~statSet)) |=> ((chanStatus & $past(statClr & ~statSet)) == '0));

  // R5: an enabled match is visible as status in the next cycle
  assert_match_sets_status_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|statSet) |=> ((chanStatus & $past(statSet)) == $past(statSet)));

  // R7: a single-shot channel without re-arm matches no further
  assert_single_shot_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|(matchEvt & ~periodicOn & ~rearm)) |=> ((matchEvt & $past(matchEvt & ~periodicOn & ~rearm)) == '0));
endmodule

// File: rtl/mca_datapath.sv
module mca_datapath
  import mca_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strb,
  output logic [NUM_CH-1:0]             hit,
  output logic [NUM_CH-1:0][DATA_W-1:0] cntOut,
  output logic [NUM_CH-1:0][DATA_W-1:0] matchOut,
  output logic [DATA_W-1:0]             snapOut
);
  logic [NUM_CH-1:0][DATA_W-1:0] cnt, matchReg, stepVal;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    localparam int LEAD = leaderOf(i);
    logic srcAdv;
    logic [DATA_W-1:0] srcStep;

    assign stepVal[i] = cnt[i] + DATA_W'(1);
    assign srcAdv  = strb.slaveMode[i] ? strb.advance[LEAD] : strb.advance[i];
    assign srcStep = strb.slaveMode[i] ? stepVal[LEAD] : stepVal[i];
    assign hit[i]  = srcAdv && (srcStep == matchReg[i]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt[i]      <= '0;
        matchReg[i] <= '0;
      end else begin
        if (strb.cntWr[i])         cnt[i] <= strb.wrData;
        else if (strb.clearCnt[i]) cnt[i] <= '0;
        else if (strb.advance[i])  cnt[i] <= stepVal[i];
        if (strb.matchWr[i]) matchReg[i] <= strb.wrData;
      end
    end

    // R3: a load lands exactly
    assert_load_value_R3: assert property (@(posedge clk) disable iff (!rstN)
      strb.cntWr[i] |=> (cnt[i] == $past(strb.wrData)));

    // R2: no strobe, no load, no clear: the counter holds
    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.cntWr[i] || strb.clearCnt[i] || strb.advance[i]) |=> $stable(cnt[i]));

    // R6: clear on match leaves zero
    assert_clear_on_match_R6: assert property (@(posedge clk) disable iff (!rstN)
      (strb.clearCnt[i] && !strb.cntWr[i]) |=> (cnt[i] == '0));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            snapOut <= '0;
    else if (strb.snapLo) snapOut <= cnt[4];
    else if (strb.snapHi) snapOut <= cnt[6];
  end

  assign cntOut   = cnt;
  assign matchOut = matchReg;
endmodule

// File: rtl/match_chan_array.sv
module match_chan_array
  import mca_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        tickStrobe,
  input  logic [7:0]        chanIrqEn,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic [7:0]        chanStatus,
  output logic              irqOut
);
  strobe_t strb;
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0][CTRL_W-1:0] ctrlVal;
  logic [NUM_CH-1:0][DATA_W-1:0] cntVal, matchVal;
  logic [DATA_W-1:0] snapVal;
  logic [IDX_W-1:0]  idx;

  mca_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickStrobe(tickStrobe), .chanIrqEn(chanIrqEn),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .hit(hit), .strb(strb), .ctrlOut(ctrlVal), .chanStatus(chanStatus)
  );

  mca_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hit(hit),
    .cntOut(cntVal), .matchOut(matchVal), .snapOut(snapVal)
  );

  assign idx    = regAddr[2 +: IDX_W];
  assign irqOut = |chanStatus;

  always_comb begin
    regRdData = '0;
    if (regAddr[1:0] == 2'b00) begin
      case (regAddr[7:5])
        RG_CNT:  regRdData = cntVal[idx];
        RG_MAT:  regRdData = matchVal[idx];
        RG_CTL:  regRdData = DATA_W'(ctrlVal[idx]);
        default: begin
          if (regAddr == SNAP_ADDR)      regRdData = snapVal;
          else if (regAddr == STAT_ADDR) regRdData[STAT_LO +: NUM_CH] = chanStatus;
        end
      endcase
    end
  end

  // R12: the interrupt falls only after status has been emptied
  assert_irq_follows_status_R12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> (chanStatus == '0));
endmodule

// File: tb/tb_match_chan_array.sv
module tb_match_chan_array;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0;
  logic [4:0] tickStrobe = 0;
  logic [7:0] chanIrqEn = 0;
  logic regWrEn = 0, regRdEn = 0;
  logic [7:0] regAddr = 0;
  logic [31:0] regWrData = 0;
  logic [31:0] regRdData;
  logic [7:0] chanStatus;
  logic irqOut;

  int checks = 0, errors = 0;

  match_chan_array dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  logic [31:0] mCnt [8];
  logic [31:0] mMat [8];
  logic [9:0]  mCtl [8];
  bit          mArm [8];
  logic [7:0]  mStat;
  logic [31:0] mSnap;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] mRead(input logic [7:0] a);
    int k;
    k = int'(a[4:2]);
    if (a[1:0] != 0) return 0;
    case (a[7:5])
      3'b010: return mCnt[k];
      3'b100: return mMat[k];
      3'b110: return {22'b0, mCtl[k]};
      default: begin
        if (a == 8'h20) return mSnap;
        if (a == 8'h14) return {20'b0, mStat, 4'b0};
        return 0;
      end
    endcase
  endfunction

  task automatic modelReset();
    for (int k = 0; k < 8; k++) begin
      mCnt[k] = 0; mMat[k] = 0; mCtl[k] = 0; mArm[k] = 1;
    end
    mStat = 0; mSnap = 0;
  endtask

  task automatic modelStep();
    bit own [8]; bit inc [8]; bit ev [8]; bit wc [8]; bit wm [8]; bit wk [8];
    int code; int lead; bit stb;
    logic [31:0] nCnt [8];
    logic [7:0] clr;
    for (int k = 0; k < 8; k++) begin
      own[k] = (k == 0 || k == 4 || k == 6) || mCtl[k][7];
      code = mCtl[k][8] ? 0 : int'(mCtl[k][2:0]);
      stb = (code >= 1 && code <= 5) ? tickStrobe[code-1] : 1'b0;
      wc[k] = regWrEn && regAddr == 8'h40 + 8'(4*k);
      wm[k] = regWrEn && regAddr == 8'h80 + 8'(4*k);
      wk[k] = regWrEn && regAddr == 8'hC0 + 8'(4*k);
      inc[k] = own[k] && stb && !wc[k];
    end
    for (int k = 0; k < 8; k++) begin
      lead = own[k] ? k : (k < 4 ? 0 : (k < 6 ? 4 : 6));
      ev[k] = inc[lead] && (mCnt[lead] + 1 == mMat[k]) && mArm[k];
    end
    if (regRdEn && regAddr == 8'h54 && mCtl[5][9]) mSnap = mCnt[4];
    else if (regRdEn && regAddr == 8'h5C && mCtl[7][9]) mSnap = mCnt[6];
    clr = (regWrEn && regAddr == 8'h14) ? regWrData[11:4] : 8'h00;
    for (int k = 0; k < 8; k++) begin
      nCnt[k] = mCnt[k];
      if (wc[k]) nCnt[k] = regWrData;
      else if (ev[k] && own[k] && mCtl[k][3]) nCnt[k] = 0;
      else if (inc[k]) nCnt[k] = mCnt[k] + 1;
      if (wk[k] || wm[k]) mArm[k] = 1;
      else if (ev[k] && !mCtl[k][6]) mArm[k] = 0;
      if (wm[k]) mMat[k] = regWrData;
      if (wk[k]) mCtl[k] = regWrData[9:0] & (k < 4 ? 10'h0FF : 10'h3FF);
      if (ev[k] && chanIrqEn[k]) mStat[k] = 1'b1;
      else if (clr[k]) mStat[k] = 1'b0;
    end
    for (int k = 0; k < 8; k++) mCnt[k] = nCnt[k];
  endtask

  logic [31:0] lastRd;

  // one clock: inputs set after negedge, compared each cycle
  task automatic cyc(input bit wr, input bit rd, input logic [7:0] a,
                     input logic [31:0] d, input logic [4:0] tk);
    regWrEn = wr; regRdEn = rd; regAddr = a; regWrData = d; tickStrobe = tk;
    #1;
    lastRd = regRdData;
    check("R13 read data", regRdData, mRead(a));
    modelStep();
    @(negedge clk);
    check("R5 status", {24'b0, chanStatus}, {24'b0, mStat});
    check("R12 irq", {31'b0, irqOut}, {31'b0, (mStat != 0)});
    regWrEn = 0; regRdEn = 0; tickStrobe = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1, 0, a, d, 5'b0);
  endtask

  task automatic ticks(input int n, input logic [4:0] tk);
    for (int j = 0; j < n; j++) cyc(0, 0, 8'h00, 0, tk);
  endtask

  task automatic rdChk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    cyc(0, 1, a, 0, 5'b0);
    check(tag, lastRd, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq after reset", {31'b0, irqOut}, 0);
    rdChk("R1 counter4", 8'h40, 0);
    rdChk("R1 match11", 8'h9C, 0);
    rdChk("R1 control8", 8'hD0, 0);
    rdChk("R1 snapshot", 8'h20, 0);
    rdChk("R1 status", 8'h14, 0);

    // R2 clock select
    wr(8'hC0, 32'h1);
    ticks(5, 5'b00001);
    rdChk("R2 32k strobe count", 8'h40, 5);
    ticks(3, 5'b11110);
    rdChk("R2 other strobes ignored", 8'h40, 5);
    wr(8'hC0, 32'h4);
    ticks(2, 5'b01000);
    rdChk("R2 1MHz strobe count", 8'h40, 7);
    wr(8'hC0, 32'h6);
    ticks(3, 5'b11111);
    rdChk("R2 code 6 holds", 8'h40, 7);

    // R3 load beats increment
    wr(8'hC0, 32'h4);
    cyc(1, 0, 8'h40, 32'd100, 5'b01000);
    rdChk("R3 load wins", 8'h40, 100);

    // R5/R6/R7 periodic reset-on-match
    chanIrqEn = 8'hFF;
    wr(8'h80, 32'd10);
    wr(8'h40, 32'd7);
    wr(8'hC0, 32'h49);
    ticks(3, 5'b00001);
    check("R5 status bit 4", {24'b0, chanStatus}, 32'h01);
    check("R12 irq high", {31'b0, irqOut}, 1);
    rdChk("R6 counter cleared", 8'h40, 0);
    wr(8'h14, 32'h10);
    check("R11 cleared", {24'b0, chanStatus}, 0);
    check("R12 irq low", {31'b0, irqOut}, 0);
    ticks(10, 5'b00001);
    check("R7 periodic rematch", {24'b0, chanStatus}, 32'h01);
    wr(8'h14, 32'h10);
    ticks(9, 5'b00001);
    cyc(1, 0, 8'h14, 32'h10, 5'b00001);
    check("R11 set beats clear", {24'b0, chanStatus}, 32'h01);
    wr(8'h14, 32'hFF0);

    // R4 slave channel 5 follows counter 4 (now 0)
    wr(8'hC4, 32'h01);
    wr(8'h84, 32'd4);
    wr(8'h44, 32'd50);
    ticks(4, 5'b00001);
    check("R4 slave match", {24'b0, chanStatus & 8'h02}, 32'h02);
    rdChk("R4 slave counter held", 8'h44, 50);
    wr(8'h14, 32'hFF0);

    // R7 one-shot own-mode channel 6
    wr(8'hC8, 32'h81);
    wr(8'h88, 32'd2);
    wr(8'h48, 32'd0);
    ticks(2, 5'b00001);
    check("R7 first shot", {24'b0, chanStatus & 8'h04}, 32'h04);
    wr(8'h14, 32'hFF0);
    wr(8'h48, 32'd0);
    ticks(3, 5'b00001);
    check("R7 no second shot", {24'b0, chanStatus & 8'h04}, 0);
    wr(8'h48, 32'd0);
    wr(8'h88, 32'd2);
    ticks(2, 5'b00001);
    check("R7 re-armed", {24'b0, chanStatus & 8'h04}, 32'h04);
    wr(8'h14, 32'hFF0);

    // R8 control widths
    wr(8'hC4, 32'hFFFF_FFFF);
    rdChk("R8 low group width", 8'hC4, 32'hFF);
    wr(8'hD4, 32'hFFFF_FFFF);
    rdChk("R8 high group width", 8'hD4, 32'h3FF);
    wr(8'hC4, 0);
    wr(8'hD4, 0);

    // R9 stop override
    wr(8'hD0, 32'h101);
    wr(8'h50, 0);
    ticks(4, 5'b00001);
    rdChk("R9 forced stop", 8'h50, 0);
    wr(8'hD0, 32'h001);
    ticks(4, 5'b00001);
    rdChk("R9 released", 8'h50, 4);

    // R10 snapshot
    wr(8'hD0, 0);
    wr(8'h50, 32'h1234);
    wr(8'hD4, 32'h200);
    rdChk("R10 counter9 read", 8'h54, 0);
    rdChk("R10 snapshot of 8", 8'h20, 32'h1234);
    wr(8'hDC, 0);
    wr(8'h58, 32'h55);
    rdChk("R10 counter11 read no capture", 8'h5C, 0);
    rdChk("R10 snapshot kept", 8'h20, 32'h1234);
    wr(8'hDC, 32'h200);
    rdChk("R10 counter11 read capture", 8'h5C, 0);
    rdChk("R10 snapshot of 10", 8'h20, 32'h55);

    // R13 unmapped and misaligned
    rdChk("R13 unmapped", 8'h30, 0);
    rdChk("R13 misaligned", 8'h41, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule